// File: doc/BRIEF.md
# Instruction Fetch and Length Classifier

This block drives instruction fetch for a small processor core that may also run 16-bit compressed instructions. It keeps the program counter and issues one 32-bit read at that address through a valid/ready request port. It then waits for the read data. The low two bits of the returned word give the instruction length. A full-length word goes to the decoder unchanged. A compressed word goes to the decoder with only its lower half kept, as long as the compressed-enable input is high. If that input is low, the block raises an illegal-instruction trap request instead, and the raw word goes out as the trap information.

The PC moves forward by 2 or 4 when the decoder accepts an instruction. It jumps to an external trap vector when the trap request is accepted. If the decoder reports that it found no valid instruction, the block stops for good and stays stopped until the next reset. The PC loads from an entry-address input while reset is asserted, and bit 0 is always forced to zero.

The sequence has five states:
- FETCH offers the read request. It moves to WAIT when the request is accepted.
- WAIT waits for read data. It moves to ISSUE, or to TRAP for a compressed word while compressed mode is off.
- ISSUE offers the word to the decoder. It returns to FETCH on acceptance, or moves to HALT on a decode failure.
- TRAP offers the trap request. It returns to FETCH on acceptance.
- HALT is final.

Top module: `insn_fetch_seq`

## Requirements
- R1: While reset is asserted, the block requests a fetch at `entry_pc` with bit 0 cleared, and `dec_valid`, `trap_valid` and `halted` are all 0.
- R2: Each fetch is a single 32-bit read request at the current PC. The request keeps its address stable until `mem_req_ready`, and the block then waits for `mem_rsp_valid`.
- R3: A fetched word whose bits [1:0] equal 2'b11 is presented on `dec_word` unchanged, with `dec_is_short` = 0.
- R4: A fetched word with any other value in bits [1:0], while `cmp_en` = 1, is presented with `dec_is_short` = 1 and `dec_word` = {16'h0000, word[15:0]}.
- R5: A word with bits [1:0] other than 2'b11, fetched while `cmp_en` = 0, raises `trap_valid` instead of `dec_valid`. `trap_cause` is then 2, and `trap_info` is the fetched word zero-extended to the PC width.
- R6: When the decoder accepts an instruction (`dec_valid` and `dec_ready`, with `dec_fail` = 0), the next fetch address is the old PC plus 2 for a compressed word or plus 4 for a full word.
- R7: When the trap request is accepted (`trap_valid` and `trap_ready`), the next fetch address is `trap_vec` with bit 0 cleared.
- R8: An offer on `dec_valid` or `trap_valid` stays up with stable data until it is accepted. At most one of `mem_req_valid`, `dec_valid` and `trap_valid` is high at a time.
- R9: `dec_fail` = 1 while `dec_valid` is high sets `halted` = 1 until reset, and no further fetch or offer follows.
- R10: Bit 0 of `mem_req_addr` is always 0, even when `entry_pc` or `trap_vec` is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_pc | input | PC_W | Start address loaded during reset |
| cmp_en | input | 1 | Compressed instructions enabled |
| trap_vec | input | PC_W | Target address after an accepted trap |
| mem_req_valid | output | 1 | Read request offered |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | PC_W | Read address (current PC) |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data word |
| dec_valid | output | 1 | Instruction offered to the decoder |
| dec_ready | input | 1 | Decoder accepts the instruction |
| dec_fail | input | 1 | Decoder found no valid instruction |
| dec_word | output | 32 | Instruction bits for the decoder |
| dec_is_short | output | 1 | 1 for a 2-byte instruction |
| trap_valid | output | 1 | Illegal-instruction trap offered |
| trap_ready | input | 1 | Trap accepted |
| trap_cause | output | CAUSE_W | Trap cause code (2) |
| trap_info | output | PC_W | Zero-extended raw word |
| halted | output | 1 | Sequence stopped by a decode failure |

## Verification
The checks assume that memory returns exactly one `mem_rsp_valid` pulse for each accepted request, and never one while no read is outstanding. They also assume that `cmp_en` stays constant between a request and its retirement, and that `dec_fail` is only raised together with an offered instruction. The bench's memory model holds at most one read in flight and answers it after a varying delay. The bench changes `cmp_en` only while reset is held. Its decoder model drives `dec_fail` only in the cycle it accepts a visible offer.

// File: rtl/insn_fetch_pkg.sv
package insn_fetch_pkg;

    // Width of every fetch, in bits
    localparam int FETCH_W = 32;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_WAIT,
        ST_ISSUE,
        ST_TRAP,
        ST_HALT
    } fetch_state_e;

endpackage

// File: rtl/insn_len_class.sv
module insn_len_class #(
    parameter int XLEN = 64
) (
    input  logic [31:0]      word,
    input  logic             cmp_en,
    output logic             is_short,
    output logic             illegal,
    output logic [31:0]      dec_word,
    output logic [XLEN-1:0]  info
);
    // Length comes only from the two lowest bits
    assign is_short = (word[1:0] != 2'b11);
    assign illegal  = is_short & ~cmp_en;
    assign dec_word = is_short ? {16'h0000, word[15:0]} : word;
    assign info     = XLEN'(word);
endmodule

// File: rtl/insn_pc_step.sv
module insn_pc_step #(
    parameter int PC_W = 64
) (
    input  logic [PC_W-1:0] pc,
    input  logic            is_short,
    input  logic            trap_sel,
    input  logic [PC_W-1:0] trap_vec,
    output logic [PC_W-1:0] pc_next
);
    localparam logic [PC_W-1:0] STEP_SHORT = PC_W'(2);
    localparam logic [PC_W-1:0] STEP_FULL  = PC_W'(4);
    localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(1);

    always_comb begin
        if (trap_sel) begin
            pc_next = trap_vec & ALIGN_MASK;
        end else begin
            pc_next = pc + (is_short ? STEP_SHORT : STEP_FULL);
        end
    end
endmodule

// File: rtl/insn_fetch_seq.sv
module insn_fetch_seq
    import insn_fetch_pkg::*;
#(
    parameter int          PC_W        = 64,
    parameter int          CAUSE_W     = 5,
    parameter int unsigned ILLEGAL_CODE = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PC_W-1:0]      entry_pc,
    input  logic                 cmp_en,
    input  logic [PC_W-1:0]      trap_vec,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [PC_W-1:0]      mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [FETCH_W-1:0]   mem_rsp_data,
    output logic                 dec_valid,
    input  logic                 dec_ready,
    input  logic                 dec_fail,
    output logic [FETCH_W-1:0]   dec_word,
    output logic                 dec_is_short,
    output logic                 trap_valid,
    input  logic                 trap_ready,
    output logic [CAUSE_W-1:0]   trap_cause,
    output logic [PC_W-1:0]      trap_info,
    output logic                 halted
);
    localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(1);

    fetch_state_e          state_q;
    logic [PC_W-1:0]       pc_q;
    logic [PC_W-1:0]       pc_next;
    logic [FETCH_W-1:0]    word_q;
    logic [FETCH_W-1:0]    cls_in;
    logic                  cls_short;
    logic                  cls_illegal;
    logic [FETCH_W-1:0]    cls_dec;
    logic [PC_W-1:0]       cls_info;

    // Classify the arriving word in WAIT, the held word afterwards
    assign cls_in = (state_q == ST_WAIT) ? mem_rsp_data : word_q;

    insn_len_class #(.XLEN(PC_W)) u_class (
        .word     (cls_in),
        .cmp_en   (cmp_en),
        .is_short (cls_short),
        .illegal  (cls_illegal),
        .dec_word (cls_dec),
        .info     (cls_info)
    );

    insn_pc_step #(.PC_W(PC_W)) u_step (
        .pc       (pc_q),
        .is_short (cls_short),
        .trap_sel (state_q == ST_TRAP),
        .trap_vec (trap_vec),
        .pc_next  (pc_next)
    );

    // State register, PC and held word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= entry_pc & ALIGN_MASK;
            word_q  <= '0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        word_q  <= mem_rsp_data;
                        state_q <= cls_illegal ? ST_TRAP : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (dec_fail) begin
                        state_q <= ST_HALT;
                    end else if (dec_ready) begin
                        pc_q    <= pc_next;
                        state_q <= ST_FETCH;
                    end
                end
                ST_TRAP: begin
                    if (trap_ready) begin
                        pc_q    <= pc_next;
                        state_q <= ST_FETCH;
                    end
                end
                ST_HALT: state_q <= ST_HALT;
                default: state_q <= ST_HALT;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        mem_req_valid = 1'b0;
        dec_valid     = 1'b0;
        trap_valid    = 1'b0;
        halted        = 1'b0;
        unique case (state_q)
            ST_FETCH: mem_req_valid = 1'b1;
            ST_ISSUE: dec_valid     = 1'b1;
            ST_TRAP:  trap_valid    = 1'b1;
            ST_HALT:  halted        = 1'b1;
            default:  ;
        endcase
    end

    assign mem_req_addr = pc_q;
    assign dec_word     = cls_dec;
    assign dec_is_short = cls_short;
    assign trap_cause   = CAUSE_W'(ILLEGAL_CODE);
    assign trap_info    = cls_info;

endmodule

// File: rtl/insn_fetch_seq_chk.sv
module insn_fetch_seq_chk #(
    parameter int PC_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] trap_vec,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PC_W-1:0] mem_req_addr,
    input logic            dec_valid,
    input logic            dec_ready,
    input logic            dec_fail,
    input logic [31:0]     dec_word,
    input logic            dec_is_short,
    input logic            trap_valid,
    input logic            trap_ready,
    input logic [PC_W-1:0] trap_info,
    input logic            halted
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_len_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_is_short == (dec_word[1:0] != 2'b11));

    assert_trap_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> trap_info[1:0] != 2'b11 && (trap_info >> 32) == '0);

    assert_seq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_ready && !dec_fail |=>
            mem_req_addr == $past(mem_req_addr) + ($past(dec_is_short) ? PC_W'(2) : PC_W'(4)));

    assert_trap_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && trap_ready |=> mem_req_addr == ($past(trap_vec) & ~PC_W'(1)));

    assert_dec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !dec_ready && !dec_fail |=> dec_valid && $stable(dec_word));

    assert_trap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !trap_ready |=> trap_valid && $stable(trap_info));

    assert_one_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req_valid, dec_valid, trap_valid}));

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !mem_req_valid && !dec_valid && !trap_valid);

    assert_addr_even_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_addr[0] == 1'b0);
endmodule

bind insn_fetch_seq insn_fetch_seq_chk #(.PC_W(PC_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_vec      (trap_vec),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .dec_valid     (dec_valid),
    .dec_ready     (dec_ready),
    .dec_fail      (dec_fail),
    .dec_word      (dec_word),
    .dec_is_short  (dec_is_short),
    .trap_valid    (trap_valid),
    .trap_ready    (trap_ready),
    .trap_info     (trap_info),
    .halted        (halted)
);

// File: tb/test_insn_fetch_seq.sv
module test_insn_fetch_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] entry_pc = '0;
    logic        cmp_en = 1'b0;
    logic [63:0] trap_vec = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        dec_valid;
    logic        dec_ready = 1'b0;
    logic        dec_fail = 1'b0;
    logic [31:0] dec_word;
    logic        dec_is_short;
    logic        trap_valid;
    logic        trap_ready = 1'b0;
    logic [4:0]  trap_cause;
    logic [63:0] trap_info;
    logic        halted;

    always #10 clk = ~clk;

    insn_fetch_seq i_insn_fetch_seq (
        .clk(clk), .rst_n(rst_n), .entry_pc(entry_pc), .cmp_en(cmp_en),
        .trap_vec(trap_vec), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_fail(dec_fail),
        .dec_word(dec_word), .dec_is_short(dec_is_short),
        .trap_valid(trap_valid), .trap_ready(trap_ready),
        .trap_cause(trap_cause), .trap_info(trap_info), .halted(halted)
    );

    typedef struct {
        bit          is_trap;
        logic [63:0] pc;
        logic [31:0] word;
        bit          short_len;
        bit          fail;
        string       req;
    } exp_t;

    exp_t        q[$];
    logic [31:0] mem[logic [63:0]];
    logic [63:0] cur_pc;
    int          tests = 0;
    int          fails = 0;
    int          knob_m = 0;
    int          knob_d = 0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 32'h0000_0013;
    endfunction

    // Driver: places a word at the model PC and queues what must come out
    task automatic push_insn(input logic [31:0] w, input bit fail);
        exp_t e;
        bit   s;
        s = (w[1:0] != 2'b11);
        mem[cur_pc] = w;
        e.pc = cur_pc;
        e.fail = fail;
        e.short_len = s;
        if (s && !cmp_en) begin
            e.is_trap = 1'b1;
            e.word = w;
            e.req = "R5/R7";
            cur_pc = trap_vec & ~64'd1;
        end else begin
            e.is_trap = 1'b0;
            e.word = s ? {16'h0000, w[15:0]} : w;
            e.req = s ? "R4/R6" : "R3/R6";
            cur_pc = cur_pc + (s ? 64'd2 : 64'd4);
        end
        q.push_back(e);
    endtask

    task automatic start_run(input logic [63:0] ent, input bit c, input logic [63:0] tv);
        @(negedge clk);
        rst_n = 1'b0;
        mem.delete();
        q.delete();
        entry_pc = ent;
        cmp_en = c;
        trap_vec = tv;
        cur_pc = ent & ~64'd1;
    endtask

    task automatic release_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (q.size() == 0 && halted) break;
        end
        chk("R9", "queue drained", 64'(q.size()), 64'd0);
        chk("R9", "halted", 64'(halted), 64'd1);
        repeat (5) @(negedge clk);
        chk("R9", "no fetch after halt", 64'(mem_req_valid), 64'd0);
        chk("R9", "still halted", 64'(halted), 64'd1);
    endtask

    // Memory model: one read in flight, varying accept and return delay
    initial begin : mem_model
        bit          pend = 1'b0;
        int          rwait = 0;
        int          qwait = 0;
        logic [63:0] raddr = '0;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (!rst_n) begin
                pend = 1'b0;
                qwait = 0;
            end else if (pend) begin
                if (rwait == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = rd(raddr);
                    pend = 1'b0;
                end else begin
                    rwait--;
                end
            end else if (mem_req_valid) begin
                if (qwait == 0) begin
                    mem_req_ready = 1'b1;
                    pend = 1'b1;
                    raddr = mem_req_addr;
                    knob_m++;
                    rwait = knob_m % 3;
                    qwait = knob_m % 2;
                end else begin
                    qwait--;
                end
            end
        end
    end

    // Monitor and scoreboard on the decoder and trap sides
    initial begin : monitor
        int   stall = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            dec_ready = 1'b0;
            dec_fail = 1'b0;
            trap_ready = 1'b0;
            if (rst_n && (dec_valid || trap_valid)) begin
                if (stall > 0) begin
                    stall--;
                    chk("R8", "exclusive offers",
                        64'(mem_req_valid) + 64'(dec_valid && trap_valid), 64'd0);
                end else if (q.size() == 0) begin
                    chk("R8", "unexpected offer", 64'd1, 64'd0);
                end else begin
                    e = q.pop_front();
                    chk(e.req, "offer kind", 64'(trap_valid), 64'(e.is_trap));
                    chk("R2", "fetch address", mem_req_addr, e.pc);
                    if (e.is_trap) begin
                        chk(e.req, "trap cause", 64'(trap_cause), 64'd2);
                        chk(e.req, "trap info", trap_info, {32'h0, e.word});
                        trap_ready = 1'b1;
                    end else begin
                        chk(e.req, "decoder word", 64'(dec_word), 64'(e.word));
                        chk(e.req, "size tag", 64'(dec_is_short), 64'(e.short_len));
                        dec_ready = 1'b1;
                        dec_fail = e.fail;
                    end
                    knob_d++;
                    stall = knob_d % 3;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        // Run A: compressed enabled, odd entry, all four length codes
        start_run(64'h0000_0000_8000_0001, 1'b1, 64'h0);
        @(negedge clk);
        chk("R1", "reset request", 64'(mem_req_valid), 64'd1);
        chk("R10", "reset address aligned", mem_req_addr, 64'h0000_0000_8000_0000);
        chk("R1", "reset dec_valid", 64'(dec_valid), 64'd0);
        chk("R1", "reset trap_valid", 64'(trap_valid), 64'd0);
        chk("R1", "reset halted", 64'(halted), 64'd0);
        push_insn(32'h0050_0093, 1'b0);
        push_insn(32'hDEAD_4505, 1'b0);
        push_insn(32'h0000_8082, 1'b0);
        push_insn(32'h1234_0000, 1'b0);
        push_insn(32'hFFFF_FFFF, 1'b0);
        push_insn(32'h0000_0073, 1'b1);
        release_reset();
        wait_done();

        // Run B: compressed disabled, trap to an odd vector
        start_run(64'h0000_0000_0000_1000, 1'b0, 64'h0000_0000_0000_2003);
        push_insn(32'h00A0_0513, 1'b0);
        push_insn(32'hABCD_4581, 1'b0);
        push_insn(32'h0000_0013, 1'b0);
        push_insn(32'h0010_0073, 1'b1);
        release_reset();
        wait_done();

        // Run C: first word traps, vector near the top of the space
        start_run(64'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF0);
        push_insn(32'h0000_0001, 1'b0);
        push_insn(32'h0020_0073, 1'b1);
        release_reset();
        wait_done();

        // Run D: decode failure on a compressed word
        start_run(64'h0000_0000_0000_0040, 1'b1, 64'h0);
        push_insn(32'h5555_0001, 1'b1);
        release_reset();
        wait_done();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule